// File: doc/BRIEF.md
# Station Address ROM Loader

This block fetches the station hardware address of a network port from a byte-wide configuration ROM. It runs once by itself when reset is released and again each time the `start` input is pulsed while it is idle. Each run reads eight bytes, one request at a time, over a simple synchronous ROM port. The wanted bytes are spread out in the ROM: byte k lives at ROM address k × 16.

The bytes are stored with their bit order mirrored, so the block reverses every returned byte before using it. The first six reversed bytes form the 48-bit address. All eight reversed bytes, including the two trailing bytes that are not part of the address, are XORed together. The result must be all ones for the run to pass.

At the end of each run the block gives a one-clock `done` pulse together with a fail flag. The address output only ever takes a value from a run that passed.

The ROM port is a request/response link. The block raises `rom_rd` for exactly one clock with `rom_addr` valid, then waits for as long as needed for the one clock on which `rom_dv` is high. It always accepts that word on that clock, so the ROM sees no back-pressure. The block never has more than one request in flight. A `rom_dv` that comes while no request is pending is dropped.

Top module: `hwaddr_rom_loader`

## Requirements
- R1: A run makes exactly eight reads. A new `rom_rd` pulse (one clock wide) is raised only after the `rom_dv` answering the previous one, so at most one read is outstanding, whatever the ROM latency.
- R2: Read k of a run (k = 0..7) presents `rom_addr` = k × 16, so the low four address bits are always zero.
- R3: Each returned byte is bit-mirrored before use: ROM data bit i becomes bit 7−i.
- R4: The mirrored bytes 0..5, in fetch order, form `station_addr`, with byte 0 in bits [47:40] and byte 5 in bits [7:0]. Bytes 6 and 7 never appear in the address.
- R5: The run passes when the XOR of all eight mirrored bytes equals 8'hFF. Otherwise `chk_fail` is 1 from the `done` clock until the next `done`.
- R6: `done` is high for exactly one clock, two clock edges after the edge that samples the eighth `rom_dv`. `station_addr` and `chk_fail` take their new values on that same clock, and `busy` is low.
- R7: A `start` sampled while `busy` is high is ignored: the run in progress keeps its read order and count. A `start` sampled while idle begins a new run.
- R8: During reset, `done`, `chk_fail`, `rom_rd` and `station_addr` are 0. The first run begins on the first clock edge after reset is released, without any `start`.
- R9: `station_addr` stays 0 until a run passes. It changes only on a `done` clock of a passing run, so a failing run leaves the previous address in place.
- R10: A `rom_dv` that comes while no read is outstanding has no effect on the outputs or on later runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new run (honoured only while idle) |
| rom_rd | output | 1 | One-clock read request to the ROM |
| rom_addr | output | 7 | ROM byte address of the request |
| rom_dv | input | 1 | ROM data valid, one clock per request |
| rom_data | input | 8 | ROM read data, sampled when `rom_dv` is high |
| station_addr | output | 48 | Last address that passed its check |
| done | output | 1 | One-clock end-of-run pulse |
| chk_fail | output | 1 | Result of the last run: 1 = checksum mismatch |
| busy | output | 1 | A run is in progress |

## Verification
The hardest situations to reach are a `start` that lands partway through a run, and a `rom_dv` that shows up while nothing is outstanding. Both would quietly corrupt the read order or the checksum, and neither can be seen at the outputs until the next `done`.

The bench times its stray `start` pulses by counting the read requests it has already answered. It injects an unrequested `rom_dv` right after a `done`. It also changes the ROM latency between runs.

The reference model rebuilds the expected address and checksum from the actual ROM image. The first run after reset uses a corrupted image, so the zero-until-pass rule gets checked.

// File: rtl/hwaddr_pkg.sv
package hwaddr_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_CHECK = 2'd3
  } seq_state_t;

  localparam logic [7:0] SUM_GOOD = 8'hFF;
endpackage

// File: rtl/hwaddr_bitrev.sv
module hwaddr_bitrev #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_mirror
      assign dout[i] = din[W-1-i];
    end
  endgenerate
endmodule

// File: rtl/hwaddr_seq.sv
module hwaddr_seq
  import hwaddr_pkg::*;
#(
  parameter int NUM_BYTES  = 8,
  parameter int STRIDE_LOG = 4,
  parameter int IDX_W      = $clog2(NUM_BYTES),
  parameter int ROM_AW     = IDX_W + STRIDE_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic              rom_dv,
  output logic              rom_rd,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              clr,
  output logic              chk_now,
  output logic              busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  seq_state_t       state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (kick) begin
          state_q <= SEQ_ISSUE;
          idx_q   <= '0;
        end
        SEQ_ISSUE: state_q <= SEQ_WAIT;
        SEQ_WAIT: if (rom_dv) begin
          if (idx_q == LAST_IDX) begin
            state_q <= SEQ_CHECK;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SEQ_ISSUE;
          end
        end
        SEQ_CHECK: state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    rom_rd   = (state_q == SEQ_ISSUE);
    rom_addr = {idx_q, {STRIDE_LOG{1'b0}}};
    cap_en   = (state_q == SEQ_WAIT) && rom_dv;
    cap_idx  = idx_q;
    clr      = (state_q == SEQ_IDLE) && kick;
    chk_now  = (state_q == SEQ_CHECK);
    busy     = (state_q != SEQ_IDLE);
  end

  // R1: a request is one clock and is followed by a waiting phase
  assert_single_outstanding_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> (!rom_rd && busy));

  // R7: a start seen mid-run does not restart or end the run
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && busy && !chk_now) |=> busy);
endmodule

// File: rtl/hwaddr_accum.sv
module hwaddr_accum #(
  parameter int NUM_BYTES  = 8,
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = $clog2(NUM_BYTES),
  parameter int MAC_W      = 8 * ADDR_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [7:0]       byte_in,
  output logic [MAC_W-1:0] asm_addr,
  output logic [7:0]       sum
);
  logic [7:0] sum_q;

  generate
    for (genvar j = 0; j < ADDR_BYTES; j++) begin : g_octet
      logic [7:0] oct_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     oct_q <= '0;
        else if (cap_en && (cap_idx == IDX_W'(j)))      oct_q <= byte_in;
      end
      assign asm_addr[8*(ADDR_BYTES-j)-1 -: 8] = oct_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (clr)    sum_q <= '0;
    else if (cap_en) sum_q <= sum_q ^ byte_in;
  end

  assign sum = sum_q;
endmodule

// File: rtl/hwaddr_rom_loader.sv
module hwaddr_rom_loader
  import hwaddr_pkg::*;
#(
  parameter int NUM_BYTES  = 8,
  parameter int ADDR_BYTES = 6,
  parameter int STRIDE_LOG = 4,
  localparam int IDX_W     = $clog2(NUM_BYTES),
  localparam int ROM_AW    = IDX_W + STRIDE_LOG,
  localparam int MAC_W     = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rom_rd,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic              rom_dv,
  input  logic [7:0]        rom_data,
  output logic [MAC_W-1:0]  station_addr,
  output logic              done,
  output logic              chk_fail,
  output logic              busy
);
  logic             boot_q;
  logic             kick;
  logic             cap_en, clr, chk_now;
  logic [IDX_W-1:0] cap_idx;
  logic [7:0]       mirrored;
  logic [MAC_W-1:0] asm_addr;
  logic [7:0]       sum;
  logic [MAC_W-1:0] addr_q;
  logic             done_q, fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  assign kick = start | boot_q;

  hwaddr_seq #(
    .NUM_BYTES (NUM_BYTES),
    .STRIDE_LOG(STRIDE_LOG),
    .IDX_W     (IDX_W),
    .ROM_AW    (ROM_AW)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick    (kick),
    .rom_dv  (rom_dv),
    .rom_rd  (rom_rd),
    .rom_addr(rom_addr),
    .cap_en  (cap_en),
    .cap_idx (cap_idx),
    .clr     (clr),
    .chk_now (chk_now),
    .busy    (busy)
  );

  hwaddr_bitrev #(.W(8)) u_mirror (
    .din (rom_data),
    .dout(mirrored)
  );

  hwaddr_accum #(
    .NUM_BYTES (NUM_BYTES),
    .ADDR_BYTES(ADDR_BYTES),
    .IDX_W     (IDX_W),
    .MAC_W     (MAC_W)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .cap_en  (cap_en),
    .cap_idx (cap_idx),
    .byte_in (mirrored),
    .asm_addr(asm_addr),
    .sum     (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= chk_now;
      if (chk_now) begin
        fail_q <= (sum != SUM_GOOD);
        if (sum == SUM_GOOD) addr_q <= asm_addr;
      end
    end
  end

  assign station_addr = addr_q;
  assign done         = done_q;
  assign chk_fail     = fail_q;

  // R6: end-of-run indication lasts a single clock
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the address moves only together with a done pulse
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(station_addr));

  // R9: a failing run leaves the previous address in place
  assert_fail_keeps_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chk_fail) |-> $stable(station_addr));
endmodule

// File: tb/hwaddr_rom_loader_bench.sv
module hwaddr_rom_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rom_rd;
  logic [6:0]  rom_addr;
  logic        rom_dv = 1'b0;
  logic [7:0]  rom_data = 8'h00;
  logic [47:0] station_addr;
  logic        done, chk_fail, busy;

  always #5 clk = ~clk;

  hwaddr_rom_loader u_hwaddr_rom_loader (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_dv(rom_dv), .rom_data(rom_data),
    .station_addr(station_addr), .done(done), .chk_fail(chk_fail), .busy(busy)
  );

  logic [7:0]  rom_mem [0:127];
  int          rom_lat = 1;
  int          checks = 0, fails = 0;
  bit          finished = 0;
  bit          stray_req = 0;

  int          pend = 0;
  logic [6:0]  pend_addr;
  int          rd_cnt = 0, got_cnt = 0, runs_done = 0, rd_total = 0;
  int          done_cd = 0;
  logic [47:0] run_addr, exp_addr = '0;
  logic [7:0]  run_sum;
  bit          run_fail = 0, exp_fail = 0;

  function automatic logic [7:0] mirror(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // Build an image: address bytes mirrored at stride 16, extra byte 6, byte 7 closing the sum
  task automatic load_image(input logic [47:0] mac, input logic [7:0] extra, input bit good);
    logic [7:0] x;
    for (int a = 0; a < 128; a++) rom_mem[a] = 8'hA5 ^ 8'(a);
    x = 8'h00;
    for (int k = 0; k < 6; k++) begin
      rom_mem[k*16] = mirror(mac[47-8*k -: 8]);
      x = x ^ mac[47-8*k -: 8];
    end
    rom_mem[96] = mirror(extra);
    x = x ^ extra;
    rom_mem[112] = good ? mirror(~x) : mirror(~x ^ 8'h10);
  endtask

  // Reference model and ROM responder, all on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pend = 0; rd_cnt = 0; got_cnt = 0; done_cd = 0;
        rom_dv = 1'b0;
      end else begin
        bit exp_done;
        exp_done = 0;
        if (done_cd > 0) begin
          done_cd--;
          if (done_cd == 0) begin
            exp_done = 1;
            exp_fail = run_fail;
            if (!run_fail) exp_addr = run_addr;
            runs_done++;
          end
        end
        chk(done == exp_done, "R6 done timing", 64'(done), 64'(exp_done));
        chk(station_addr == exp_addr, "R4/R9 station_addr", 64'(station_addr), 64'(exp_addr));
        chk(chk_fail == exp_fail, "R5 chk_fail", 64'(chk_fail), 64'(exp_fail));
        if (exp_done) chk(busy == 1'b0, "R6 busy low at done", 64'(busy), 64'd0);

        rom_dv = 1'b0;
        if (stray_req) begin
          rom_dv = 1'b1; rom_data = 8'h3C; stray_req = 0;
        end else if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            logic [7:0] m;
            rom_dv = 1'b1;
            rom_data = rom_mem[pend_addr];
            m = mirror(rom_data);
            if (got_cnt == 0) run_sum = 8'h00;
            if (got_cnt < 6) run_addr[47-8*got_cnt -: 8] = m;
            run_sum = run_sum ^ m;
            got_cnt++;
            if (got_cnt == 8) begin
              got_cnt = 0;
              run_fail = (run_sum != 8'hFF);
              done_cd = 2;
            end
          end
        end
        if (rom_rd) begin
          chk(pend == 0 && !rom_dv, "R1 read while one outstanding", 64'(pend), 64'd0);
          chk(rom_addr == 7'(rd_cnt * 16), "R2 read address", 64'(rom_addr), 64'(rd_cnt * 16));
          pend = rom_lat;
          pend_addr = rom_addr;
          rd_cnt = (rd_cnt + 1) % 8;
          rd_total++;
        end
      end
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic wait_runs(input int n);
    while (runs_done < n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk); start = 1'b1;
    repeat (len) @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired, runs=%0d expected more", runs_done);
    finish_up();
  end

  initial begin
    // R8/R9: first image is corrupt so the address must stay zero
    load_image(48'h0203_0405_0607, 8'h5A, 1'b0);
    repeat (3) @(negedge clk);
    chk(done == 0 && chk_fail == 0 && rom_rd == 0 && station_addr == 0,
        "R8 reset values", {done, chk_fail, rom_rd}, 64'd0);
    rst_n = 1'b1;
    wait_runs(1);
    chk(rd_total == 8, "R8 auto run after reset, R1 eight reads", 64'(rd_total), 64'd8);
    chk(chk_fail == 1'b1, "R5 bad checksum flagged", 64'(chk_fail), 64'd1);
    chk(station_addr == 48'h0, "R9 address zero before first pass", station_addr, 64'd0);

    // R3/R4/R7: good image, start pulses mid-run
    load_image(48'hA1B2_C3D4_E5F6, 8'h81, 1'b1);
    pulse_start(1);
    while (rd_total < 11) @(posedge clk);
    pulse_start(1);
    while (rd_total < 14) @(posedge clk);
    pulse_start(2);
    wait_runs(2);
    chk(rd_total == 16, "R7 mid-run start ignored", 64'(rd_total), 64'd16);
    chk(station_addr == 48'hA1B2_C3D4_E5F6, "R3/R4 address assembled", station_addr, 64'hA1B2_C3D4_E5F6);
    chk(chk_fail == 1'b0, "R5 good checksum passes", 64'(chk_fail), 64'd0);

    // R10: unrequested data-valid while idle
    #1 stray_req = 1;
    repeat (5) @(negedge clk);
    chk(runs_done == 2 && station_addr == 48'hA1B2_C3D4_E5F6, "R10 stray data-valid ignored",
        station_addr, 64'hA1B2_C3D4_E5F6);

    // Longer latency, start held several clocks
    rom_lat = 4;
    load_image(48'h0180_C2FF_0011, 8'h00, 1'b1);
    pulse_start(4);
    wait_runs(3);
    chk(rd_total == 24, "R1 eight reads with latency 4", 64'(rd_total), 64'd24);
    chk(station_addr == 48'h0180_C2FF_0011, "R4 address with slow ROM", station_addr, 64'h0180_C2FF_0011);

    // R9: failing run keeps previous address; byte 6 change only affects sum
    rom_lat = 2;
    load_image(48'hDEAD_BEEF_0000, 8'h77, 1'b0);
    pulse_start(1);
    wait_runs(4);
    chk(chk_fail == 1'b1, "R5 corrupt image flagged", 64'(chk_fail), 64'd1);
    chk(station_addr == 48'h0180_C2FF_0011, "R9 failing run keeps address", station_addr, 64'h0180_C2FF_0011);

    // R4: byte 6 differs, address identical
    load_image(48'hDEAD_BEEF_0000, 8'h12, 1'b1);
    pulse_start(1);
    wait_runs(5);
    chk(station_addr == 48'hDEAD_BEEF_0000 && chk_fail == 0, "R4 trailing bytes not in address",
        station_addr, 64'hDEAD_BEEF_0000);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule